// File: doc/BRIEF.md
# Bayer colour interpolator

This block turns a raster stream of raw colour-filter-array samples into a full red, green and blue triple for every pixel. Each pixel is rebuilt from its 3×3 neighbourhood. Two on-chip line stores keep the two lines received before the current one. A three-column window register then assembles the neighbourhood as pixels arrive. Missing neighbours at any edge of the frame are filled by copying the nearest pixel that exists.

A pixel is accepted on every cycle where `in_valid` is high. `in_sol` marks the first pixel of a line, and `in_sof` marks the first pixel of a frame, which is also the first pixel of a line. Results leave the block one line and one pixel behind the input. The last column of a line is released by the first pixel of the next line. The last line of a frame is therefore flushed by one further line that starts with `in_sof`, followed by one pixel that starts a line. A 2-bit phase input names the colour of the first pixel of each frame. A bypass input serves monochrome sensors: it copies the centre sample to all three outputs at full resolution.

Top module: `bayer_demosaic`

## Requirements
- R1: While `rst_n` is low, and on the first clock edges after its release, `out_valid` is 0.
- R2: Pixel (row y, column x) of a frame of width W is emitted, in raster order, one cycle after the input pixel (y+1, x+1) is accepted. When x = W−1, it is emitted one cycle after the first pixel of line y+2 is accepted. Emission happens only if line y+1 was received.
- R3: At a red site, R is the centre sample, G is the truncated mean of the four orthogonal neighbours, and B is the truncated mean of the four diagonal neighbours. At a blue site the roles of R and B are swapped.
- R4: At a green site, the colour that shares the current row is the truncated mean of the left and right neighbours. The other colour is the truncated mean of the neighbours above and below. G is the centre sample.
- R5: `cfg_phase` gives the 2×2 tile at row 0, column 0 as 0 = R G / G B, 1 = G R / B G, 2 = G B / R G, 3 = B G / G R. The colour at (y, x) is the tile entry at (y mod 2, x mod 2).
- R6: A neighbour above row 0 takes the value of row 0. A neighbour below the last row of a frame takes the value of that last row.
- R7: A neighbour left of column 0 takes the value of column 0. A neighbour right of column W−1 takes the value of column W−1.
- R8: With `cfg_bypass` high, `out_r`, `out_g` and `out_b` all equal the centre sample.
- R9: Cycles with `in_valid` low neither advance the stream nor produce output. `out_valid` is high only in the cycle after an accepted pixel, and the output data hold while `out_valid` is low.
- R10: Lines of up to `MAX_W` pixels, including exactly `MAX_W`, are interpolated correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel strobe |
| in_pix | input | PIX_W | Raw sample |
| in_sol | input | 1 | First pixel of a line |
| in_sof | input | 1 | First pixel of a frame |
| cfg_phase | input | 2 | Colour at row 0, column 0 |
| cfg_bypass | input | 1 | Monochrome pass-through |
| out_valid | output | 1 | Output triple strobe |
| out_r | output | PIX_W | Red |
| out_g | output | PIX_W | Green |
| out_b | output | PIX_W | Blue |

## Verification
The bench builds the block with `MAX_W` = 8 and `PIX_W` = 10. This lets it fill a line store to its last entry and sweep every pixel of small frames, for all four phases and for bypass. Frames of width 1 and height 1 make every neighbour a replicated one. Frames near full scale check that the four-sample sums do not overflow. Idle gaps are inserted regularly, and the accepted-pixel count at each emission is compared with the position R2 predicts.

// File: rtl/bayer_pkg.sv
package bayer_pkg;

  typedef enum logic [1:0] {
    SITE_RED   = 2'b00,
    SITE_G_RR  = 2'b01,
    SITE_G_BR  = 2'b10,
    SITE_BLUE  = 2'b11
  } site_e;

  function automatic site_e site_of(input logic [1:0] phase,
                                    input logic       row_par,
                                    input logic       col_par);
    return site_e'({row_par ^ phase[1], col_par ^ phase[0]});
  endfunction

endpackage

// File: rtl/bayer_linebuf.sv
module bayer_linebuf #(
  parameter int PIX_W  = 10,
  parameter int DEPTH  = 800,
  parameter int NLINES = 2,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                          clk,
  input  logic                          wr_en,
  input  logic [AW-1:0]                 addr,
  input  logic [PIX_W-1:0]              din,
  output logic [NLINES-1:0][PIX_W-1:0]  rd
);

  for (genvar k = 0; k < NLINES; k++) begin : g_line
    logic [PIX_W-1:0] mem [DEPTH];
    logic [PIX_W-1:0] wdata;

    if (k == 0) begin : g_head
      assign wdata = din;
    end else begin : g_chain
      assign wdata = rd[k-1];
    end

    assign rd[k] = mem[addr];

    always_ff @(posedge clk) begin
      if (wr_en) begin
        mem[addr] <= wdata;
      end
    end
  end

endmodule

// File: rtl/bayer_interp.sv
module bayer_interp
  import bayer_pkg::*;
#(
  parameter int PIX_W = 10
) (
  input  logic [8:0][PIX_W-1:0] win,
  input  site_e                 site,
  input  logic                  bypass,
  output logic [PIX_W-1:0]      r,
  output logic [PIX_W-1:0]      g,
  output logic [PIX_W-1:0]      b
);

  localparam int SW = PIX_W + 2;

  logic [SW-1:0]    orth_sum, diag_sum, horz_sum, vert_sum;
  logic [PIX_W-1:0] orth_avg, diag_avg, horz_avg, vert_avg, ctr;

  always_comb begin
    ctr      = win[4];
    orth_sum = SW'(win[1]) + SW'(win[7]) + SW'(win[3]) + SW'(win[5]);
    diag_sum = SW'(win[0]) + SW'(win[2]) + SW'(win[6]) + SW'(win[8]);
    horz_sum = SW'(win[3]) + SW'(win[5]);
    vert_sum = SW'(win[1]) + SW'(win[7]);
    orth_avg = orth_sum[SW-1:2];
    diag_avg = diag_sum[SW-1:2];
    horz_avg = horz_sum[PIX_W:1];
    vert_avg = vert_sum[PIX_W:1];

    if (bypass) begin
      r = ctr; g = ctr; b = ctr;
    end else begin
      unique case (site)
        SITE_RED:  begin r = ctr;      g = orth_avg; b = diag_avg; end
        SITE_BLUE: begin r = diag_avg; g = orth_avg; b = ctr;      end
        SITE_G_RR: begin r = horz_avg; g = ctr;      b = vert_avg; end
        default:   begin r = vert_avg; g = ctr;      b = horz_avg; end
      endcase
    end
  end

endmodule

// File: rtl/bayer_demosaic.sv
module bayer_demosaic
  import bayer_pkg::*;
#(
  parameter int PIX_W = 10,
  parameter int MAX_W = 800
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] in_pix,
  input  logic             in_sol,
  input  logic             in_sof,
  input  logic [1:0]       cfg_phase,
  input  logic             cfg_bypass,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_r,
  output logic [PIX_W-1:0] out_g,
  output logic [PIX_W-1:0] out_b
);

  localparam int AW = $clog2(MAX_W);
  localparam int XW = $clog2(MAX_W + 1);

  typedef logic [2:0][PIX_W-1:0] col_t;  // [0]=above [1]=centre row [2]=below

  // line state
  logic [XW-1:0] xcnt_q, xcnt_d;
  logic          rpar_q, rpar_d, first_q, first_d, seen_q, seen_d;
  logic          mpar_q, mpar_d, mtop_q, mtop_d, midok_q, midok_d;
  // window state
  col_t          w0_q, w0_d, w1_q, w1_d;
  logic          w0_first_q, w0_first_d, w0_cpar_q, w0_cpar_d;
  logic          pend_q, pend_d;
  // output
  logic          ov_q;
  logic [PIX_W-1:0] or_q, og_q, ob_q;

  // combinational
  logic                         start, emit;
  logic [XW-1:0]                x_cur;
  logic                         eff_top, eff_bot, eff_ok;
  logic [1:0][PIX_W-1:0]        lb_rd;
  col_t                         new_col, left_col, right_col;
  logic [8:0][PIX_W-1:0]        win;
  logic [PIX_W-1:0]             ip_r, ip_g, ip_b;
  site_e                        site;

  assign start = in_valid & (in_sol | in_sof);
  assign x_cur = start ? '0 : xcnt_q;

  bayer_linebuf #(.PIX_W(PIX_W), .DEPTH(MAX_W), .NLINES(2)) u_lines (
    .clk   (clk),
    .wr_en (in_valid),
    .addr  (x_cur[AW-1:0]),
    .din   (in_pix),
    .rd    (lb_rd)
  );

  always_comb begin
    eff_top    = start ? first_q : mtop_q;
    eff_bot    = start ? in_sof  : first_q;
    eff_ok     = start ? seen_q  : midok_q;
    new_col[0] = eff_top ? lb_rd[0] : lb_rd[1];
    new_col[1] = lb_rd[0];
    new_col[2] = eff_bot ? lb_rd[0] : in_pix;
    left_col   = w0_first_q ? w0_q : w1_q;
    right_col  = start ? w0_q : new_col;
    for (int rr = 0; rr < 3; rr++) begin
      win[rr*3 + 0] = left_col[rr];
      win[rr*3 + 1] = w0_q[rr];
      win[rr*3 + 2] = right_col[rr];
    end
    site = site_of(cfg_phase, mpar_q, w0_cpar_q);
    emit = in_valid & pend_q;
  end

  bayer_interp #(.PIX_W(PIX_W)) u_interp (
    .win    (win),
    .site   (site),
    .bypass (cfg_bypass),
    .r      (ip_r),
    .g      (ip_g),
    .b      (ip_b)
  );

  // next state
  always_comb begin
    xcnt_d     = xcnt_q;
    rpar_d     = rpar_q;
    first_d    = first_q;
    seen_d     = seen_q;
    mpar_d     = mpar_q;
    mtop_d     = mtop_q;
    midok_d    = midok_q;
    w0_d       = w0_q;
    w1_d       = w1_q;
    w0_first_d = w0_first_q;
    w0_cpar_d  = w0_cpar_q;
    pend_d     = pend_q;
    if (in_valid) begin
      xcnt_d     = x_cur + XW'(1);
      w1_d       = w0_q;
      w0_d       = new_col;
      w0_first_d = start;
      w0_cpar_d  = x_cur[0];
      pend_d     = eff_ok;
      if (start) begin
        rpar_d  = in_sof ? 1'b0 : ~rpar_q;
        first_d = in_sof;
        seen_d  = 1'b1;
        mpar_d  = rpar_q;
        mtop_d  = first_q;
        midok_d = seen_q;
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xcnt_q     <= '0;
      rpar_q     <= 1'b0;
      first_q    <= 1'b0;
      seen_q     <= 1'b0;
      mpar_q     <= 1'b0;
      mtop_q     <= 1'b0;
      midok_q    <= 1'b0;
      w0_q       <= '0;
      w1_q       <= '0;
      w0_first_q <= 1'b0;
      w0_cpar_q  <= 1'b0;
      pend_q     <= 1'b0;
    end else begin
      xcnt_q     <= xcnt_d;
      rpar_q     <= rpar_d;
      first_q    <= first_d;
      seen_q     <= seen_d;
      mpar_q     <= mpar_d;
      mtop_q     <= mtop_d;
      midok_q    <= midok_d;
      w0_q       <= w0_d;
      w1_q       <= w1_d;
      w0_first_q <= w0_first_d;
      w0_cpar_q  <= w0_cpar_d;
      pend_q     <= pend_d;
    end
  end

  // output registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q <= 1'b0;
      or_q <= '0;
      og_q <= '0;
      ob_q <= '0;
    end else begin
      ov_q <= emit;
      if (emit) begin
        or_q <= ip_r;
        og_q <= ip_g;
        ob_q <= ip_b;
      end
    end
  end

  assign out_valid = ov_q;
  assign out_r     = or_q;
  assign out_g     = og_q;
  assign out_b     = ob_q;

endmodule

// File: rtl/bayer_demosaic_chk.sv
module bayer_demosaic_chk #(
  parameter int PIX_W = 10,
  parameter int MAX_W = 800,
  localparam int XW   = $clog2(MAX_W + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_sol,
  input logic             in_sof,
  input logic             cfg_bypass,
  input logic             out_valid,
  input logic [PIX_W-1:0] out_r,
  input logic [PIX_W-1:0] out_g,
  input logic [PIX_W-1:0] out_b,
  input logic             pend_q,
  input logic [XW-1:0]    xcnt_q
);

  p_out_after_input_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  p_hold_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_r) && $stable(out_g) && $stable(out_b)));

  p_bypass_grey_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(cfg_bypass)) |-> (out_r == out_g && out_g == out_b));

  p_line_start_flush_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_sol || in_sof) && pend_q) |=> out_valid);

  p_col_limit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    xcnt_q <= XW'(MAX_W));

endmodule

bind bayer_demosaic bayer_demosaic_chk #(.PIX_W(PIX_W), .MAX_W(MAX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_sol     (in_sol),
  .in_sof     (in_sof),
  .cfg_bypass (cfg_bypass),
  .out_valid  (out_valid),
  .out_r      (out_r),
  .out_g      (out_g),
  .out_b      (out_b),
  .pend_q     (pend_q),
  .xcnt_q     (xcnt_q)
);

// File: tb/bayer_demosaic_tb.sv
module bayer_demosaic_tb;

  localparam int CLK_P = 10;
  localparam int PW    = 10;
  localparam int MW    = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [PW-1:0] in_pix = '0;
  logic          in_sol = 1'b0;
  logic          in_sof = 1'b0;
  logic [1:0]    cfg_phase = 2'd0;
  logic          cfg_bypass = 1'b0;
  logic          out_valid;
  logic [PW-1:0] out_r, out_g, out_b;

  int checks = 0;
  int errors = 0;
  int sent   = 0;
  int ncap   = 0;
  bit done   = 1'b0;
  int cap_r [64];
  int cap_g [64];
  int cap_b [64];
  int cap_s [64];

  always #(CLK_P/2) clk = ~clk;

  bayer_demosaic #(.PIX_W(PW), .MAX_W(MW)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_pix     (in_pix),
    .in_sol     (in_sol),
    .in_sof     (in_sof),
    .cfg_phase  (cfg_phase),
    .cfg_bypass (cfg_bypass),
    .out_valid  (out_valid),
    .out_r      (out_r),
    .out_g      (out_g),
    .out_b      (out_b)
  );

  // capture away from the active edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (rst_n && out_valid && ncap < 64) begin
        cap_r[ncap] = int'(out_r);
        cap_g[ncap] = int'(out_g);
        cap_b[ncap] = int'(out_b);
        cap_s[ncap] = sent;
        ncap++;
      end
    end
  end

  function automatic int pv(int t, int r, int c);
    if (t == 7) return ((r + c) % 2 == 1) ? 1023 : 1020;
    return (r*97 + c*53 + t*31 + r*c*7) % 1024;
  endfunction

  function automatic int px(int t, int r, int c, int w, int h);
    int rr = (r < 0) ? 0 : ((r >= h) ? h - 1 : r);
    int cc = (c < 0) ? 0 : ((c >= w) ? w - 1 : c);
    return pv(t, rr, cc);
  endfunction

  task automatic chk(string tag, bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic run(int t, int w, int h, int ph, bit byp);
    int slot = 0;
    rst_n      = 1'b0;
    in_valid   = 1'b0;
    cfg_phase  = 2'(ph);
    cfg_bypass = byp;
    repeat (3) @(negedge clk);
    ncap = 0;
    sent = 0;
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1", out_valid == 1'b0, "out_valid after reset", int'(out_valid), 0);
    for (int r = 0; r <= h + 1; r++) begin
      for (int c = 0; c < ((r == h + 1) ? 1 : w); c++) begin
        // R9: idle slot on every third cycle
        if (slot % 3 == 2) begin
          in_valid = 1'b0;
          @(negedge clk);
        end
        slot++;
        in_valid = 1'b1;
        in_pix   = (r < h) ? PW'(pv(t, r, c)) : PW'(11 * c + 5);
        in_sol   = (c == 0);
        in_sof   = (c == 0) && (r == 0 || r == h);
        sent++;
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
    in_sol   = 1'b0;
    in_sof   = 1'b0;
    repeat (4) @(negedge clk);

    chk((w == MW) ? "R10" : "R9", ncap == w*h, "output count", ncap, w*h);
    for (int k = 0; k < w*h && k < ncap; k++) begin
      int r = k / w;
      int c = k % w;
      int ev_s = (c < w - 1) ? (r + 1)*w + c + 2 : (r + 2)*w + 1;
      int n  = px(t, r-1, c, w, h), s  = px(t, r+1, c, w, h);
      int we = px(t, r, c-1, w, h), ea = px(t, r, c+1, w, h);
      int d  = px(t, r-1, c-1, w, h) + px(t, r-1, c+1, w, h)
             + px(t, r+1, c-1, w, h) + px(t, r+1, c+1, w, h);
      int ctr = pv(t, r, c);
      int site = (((r % 2) ^ (ph / 2)) << 1) | ((c % 2) ^ (ph % 2));
      int er, eg, eb;
      string tag;
      if (byp) begin
        er = ctr; eg = ctr; eb = ctr;
      end else if (site == 0) begin
        er = ctr; eg = (n + s + we + ea) / 4; eb = d / 4;
      end else if (site == 3) begin
        eb = ctr; eg = (n + s + we + ea) / 4; er = d / 4;
      end else if (site == 1) begin
        eg = ctr; er = (we + ea) / 2; eb = (n + s) / 2;
      end else begin
        eg = ctr; eb = (we + ea) / 2; er = (n + s) / 2;
      end
      if (byp)                         tag = "R8";
      else if (r == 0 || r == h - 1)   tag = "R6";
      else if (c == 0 || c == w - 1)   tag = "R7";
      else if (w == MW)                tag = "R10";
      else if (ph != 0)                tag = "R5";
      else if (site == 0 || site == 3) tag = "R3";
      else                             tag = "R4";
      chk("R2", cap_s[k] == ev_s, $sformatf("t%0d emission point (%0d,%0d)", t, r, c), cap_s[k], ev_s);
      chk(tag, cap_r[k] == er, $sformatf("t%0d red (%0d,%0d)", t, r, c), cap_r[k], er);
      chk(tag, cap_g[k] == eg, $sformatf("t%0d green (%0d,%0d)", t, r, c), cap_g[k], eg);
      chk(tag, cap_b[k] == eb, $sformatf("t%0d blue (%0d,%0d)", t, r, c), cap_b[k], eb);
    end
  endtask

  initial begin
    run(0, 6, 5, 0, 1'b0);   // R3 R4 R6 R7
    run(1, 6, 5, 1, 1'b0);   // R5
    run(2, 6, 5, 2, 1'b0);   // R5
    run(3, 6, 5, 3, 1'b0);   // R5
    run(4, 5, 3, 2, 1'b1);   // R8
    run(5, MW, 4, 1, 1'b0);  // R10
    run(6, 1, 3, 0, 1'b0);   // R7 single column
    run(7, 3, 1, 3, 1'b0);   // R6 single row, near full scale
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule